// File: doc/BRIEF.md
# Common-Mode Minimising Switching State Generator

This block turns a chosen base voltage vector of a five-level multilevel converter, given as integer coordinates on a 60-degree (g-h) grid, into one three-phase switching state. Each phase sits at one of the signed levels -2 to +2. A base vector can usually be reached by several redundant states. These states differ only by an offset common to all three phases, so the block indexes them with one integer `j` that is the phase-a level. It keeps the candidates whose three levels all stay in range, and it outputs the one whose level sum (the common-mode value) has the smallest magnitude.

All candidates are evaluated in parallel. A strobe on `start_i` samples the coordinates, and the result is registered one clock later with a one-cycle `done_o` pulse. When no candidate is in range, the coordinates lie outside the hexagon. In that case the block raises `err_o` together with `done_o` and keeps its previous state. The outputs hold between requests, so a modulator downstream can read them at any time.

Top module: `cm_state_gen`

## Requirements
- R1: For a result with `err_o` low, `sa_o - sb_o` equals the sampled `vg_i` and `sb_o - sc_o` equals the sampled `vh_i`. Phase a is the candidate index j, phase b is j - g, and phase c is j - g - h.
- R2: Each of `sa_o`, `sb_o` and `sc_o` always lies within -2 to +2, in two's complement.
- R3: Among all of the 125 level triples that realise the sampled (g, h), the output state has the smallest |a + b + c|.
- R4: When candidates are equal in |a + b + c|, the one with the smaller |j| wins, and after that the lower j.
- R5: `cm_o` equals `sa_o + sb_o + sc_o`, signed.
- R6: `done_o` is high for exactly the cycle that follows a cycle with `start_i` high, and low at all other times. Back-to-back strobes give back-to-back results.
- R7: When no triple realises the sampled (g, h), `err_o` is high together with `done_o`, and `sa_o`, `sb_o`, `sc_o` and `cm_o` keep their previous values. `err_o` is low whenever `done_o` is low.
- R8: While `rst_n` is low, every level, `cm_o`, `done_o` and `err_o` are zero.
- R9: In cycles that follow no strobe, the state outputs do not change, whatever `vg_i` and `vh_i` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe; samples the coordinates |
| vg_i | input | CW | Signed g coordinate of the base vector |
| vh_i | input | CW | Signed h coordinate of the base vector |
| sa_o | output | LW | Signed level of phase a |
| sb_o | output | LW | Signed level of phase b |
| sc_o | output | LW | Signed level of phase c |
| cm_o | output | SW | Signed common-mode sum of the three levels |
| done_o | output | 1 | One-cycle pulse when a result is registered |
| err_o | output | 1 | Set with done when the vector is outside the hexagon |

## Verification
The bench sweeps every coordinate pair from -6 to +6. This covers the hexagon corners, where only one j is in range, and the points just outside, where none is. A design with an off-by-one range test would either flag corner vectors as errors or emit a level of ±3. The bench interleaves valid and invalid requests, back-to-back strobes, and input changes with no strobe. A design that overwrote the state on an error, or that tracked its inputs without a strobe, shows up as a changed level. A wrong tie order or a wrong minimisation gives a larger |cm_o| than the exhaustive search over all 125 triples.

// File: rtl/cm_sel_pkg.sv
package cm_sel_pkg;

    // Ordering key: smaller is better. Common-mode magnitude first,
    // then |j|, then the negative side of j before the positive side.
    function automatic int unsigned rank_key(input int sum, input int j);
        int unsigned as;
        int unsigned aj;
        as = (sum < 0) ? int'(-sum) : int'(sum);
        aj = (j < 0) ? int'(-j) : int'(j);
        return (as << 4) | (aj << 1) | ((j > 0) ? 1 : 0);
    endfunction

endpackage

// File: rtl/cm_sel_cand.sv
module cm_sel_cand
    import cm_sel_pkg::*;
#(
    parameter int CW   = 4,
    parameter int LW   = 3,
    parameter int MAXL = 2,
    parameter int KW   = 8,
    parameter int JV   = 0
) (
    input  logic signed [CW-1:0] g_i,
    input  logic signed [CW-1:0] h_i,
    output logic                 ok_o,
    output logic signed [LW-1:0] sa_o,
    output logic signed [LW-1:0] sb_o,
    output logic signed [LW-1:0] sc_o,
    output logic [KW-1:0]        key_o
);
    localparam int EW = CW + 3;

    logic signed [EW-1:0] a_w, b_w, c_w;
    int unsigned          key_w;

    always_comb begin
        a_w   = EW'(JV);
        b_w   = a_w - EW'(g_i);
        c_w   = b_w - EW'(h_i);
        ok_o  = (int'(b_w) >= -MAXL) && (int'(b_w) <= MAXL) &&
                (int'(c_w) >= -MAXL) && (int'(c_w) <= MAXL);
        sa_o  = LW'(a_w);
        sb_o  = LW'(b_w);
        sc_o  = LW'(c_w);
        key_w = rank_key(int'(a_w) + int'(b_w) + int'(c_w), JV);
        key_o = KW'(key_w);
    end
endmodule

// File: rtl/cm_sel_pick.sv
module cm_sel_pick #(
    parameter int NJ = 5,
    parameter int KW = 8,
    parameter int IW = 3
) (
    input  logic [NJ-1:0]    ok_i,
    input  logic [NJ*KW-1:0] keys_i,
    output logic             any_o,
    output logic [IW-1:0]    idx_o
);
    logic [KW-1:0] best_key;

    always_comb begin
        any_o    = 1'b0;
        idx_o    = '0;
        best_key = '1;
        for (int k = 0; k < NJ; k++) begin
            if (ok_i[k] && (!any_o || keys_i[k*KW +: KW] < best_key)) begin
                any_o    = 1'b1;
                idx_o    = IW'(k);
                best_key = keys_i[k*KW +: KW];
            end
        end
    end
endmodule

// File: rtl/cm_state_gen.sv
module cm_state_gen #(
    parameter int LEVELS = 5,
    parameter int CW     = 4,
    localparam int MAXL  = (LEVELS - 1) / 2,
    localparam int LW    = $clog2(MAXL + 1) + 1,
    localparam int SW    = $clog2(3 * MAXL + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic signed [CW-1:0] vg_i,
    input  logic signed [CW-1:0] vh_i,
    output logic signed [LW-1:0] sa_o,
    output logic signed [LW-1:0] sb_o,
    output logic signed [LW-1:0] sc_o,
    output logic signed [SW-1:0] cm_o,
    output logic                 done_o,
    output logic                 err_o
);
    localparam int NJ = 2 * MAXL + 1;
    localparam int KW = 8;
    localparam int IW = (NJ > 1) ? $clog2(NJ) : 1;

    typedef struct packed {
        logic signed [LW-1:0] sa;
        logic signed [LW-1:0] sb;
        logic signed [LW-1:0] sc;
        logic signed [SW-1:0] cm;
        logic                 done;
        logic                 err;
    } st_t;

    st_t st_d, st_q;

    logic [NJ-1:0]        ok_c;
    logic [NJ*KW-1:0]     key_c;
    logic signed [LW-1:0] sa_c [NJ];
    logic signed [LW-1:0] sb_c [NJ];
    logic signed [LW-1:0] sc_c [NJ];
    logic                 any_c;
    logic [IW-1:0]        idx_c;

    for (genvar k = 0; k < NJ; k++) begin : g_cand
        cm_sel_cand #(
            .CW(CW), .LW(LW), .MAXL(MAXL), .KW(KW), .JV(k - MAXL)
        ) cand_i (
            .g_i   (vg_i),
            .h_i   (vh_i),
            .ok_o  (ok_c[k]),
            .sa_o  (sa_c[k]),
            .sb_o  (sb_c[k]),
            .sc_o  (sc_c[k]),
            .key_o (key_c[k*KW +: KW])
        );
    end

    cm_sel_pick #(.NJ(NJ), .KW(KW), .IW(IW)) pick_i (
        .ok_i   (ok_c),
        .keys_i (key_c),
        .any_o  (any_c),
        .idx_o  (idx_c)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = start_i;
        st_d.err  = start_i && !any_c;
        if (start_i && any_c) begin
            st_d.sa = sa_c[idx_c];
            st_d.sb = sb_c[idx_c];
            st_d.sc = sc_c[idx_c];
            st_d.cm = SW'(sa_c[idx_c]) + SW'(sb_c[idx_c]) + SW'(sc_c[idx_c]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sa_o   = st_q.sa;
    assign sb_o   = st_q.sb;
    assign sc_o   = st_q.sc;
    assign cm_o   = st_q.cm;
    assign done_o = st_q.done;
    assign err_o  = st_q.err;

    // R6
    done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    // R6
    done_only_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    // R1
    phase_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && any_c |=> (int'(sa_o) - int'(sb_o) == int'($past(vg_i))) &&
                             (int'(sb_o) - int'(sc_o) == int'($past(vh_i))));
    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(sa_o) && $stable(sb_o) && $stable(sc_o) && $stable(cm_o));
    // R7
    err_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(sa_o) && $stable(sb_o) && $stable(sc_o));
    // R2
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sa_o) >= -MAXL) && (int'(sa_o) <= MAXL) &&
        (int'(sb_o) >= -MAXL) && (int'(sb_o) <= MAXL) &&
        (int'(sc_o) >= -MAXL) && (int'(sc_o) <= MAXL));
    // R5
    cm_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !err_o |-> int'(cm_o) == int'(sa_o) + int'(sb_o) + int'(sc_o));
endmodule

// File: tb/cm_state_gen_tb.sv
module cm_state_gen_tb_top;
    localparam int CW = 4;
    localparam int LW = 3;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [CW-1:0] vg = '0, vh = '0;
    logic signed [LW-1:0] sa, sb, sc;
    logic signed [SW-1:0] cm;
    logic done, err;

    int checks = 0;
    int fails  = 0;

    int  e_a = 0, e_b = 0, e_c = 0, e_cm = 0;
    bit  e_done = 0, e_err = 0;
    bit  armed = 0;
    int  lfsr = 32'h1ACE5;

    always #2.5 clk = ~clk;

    cm_state_gen #(.LEVELS(5), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .vg_i(vg), .vh_i(vh),
        .sa_o(sa), .sb_o(sb), .sc_o(sc), .cm_o(cm), .done_o(done), .err_o(err)
    );

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    // Exhaustive search over all 125 triples with the stated ordering.
    task automatic ref_search(input int g, input int h, output bit found,
                              output int ra, output int rb, output int rc);
        found = 0; ra = 0; rb = 0; rc = 0;
        for (int a = -2; a <= 2; a++)
            for (int b = -2; b <= 2; b++)
                for (int c = -2; c <= 2; c++)
                    if (a - b == g && b - c == h) begin
                        if (!found ||
                            iabs(a+b+c) < iabs(ra+rb+rc) ||
                            (iabs(a+b+c) == iabs(ra+rb+rc) && iabs(a) < iabs(ra))) begin
                            found = 1; ra = a; rb = b; rc = c;
                        end
                    end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (g=%0d h=%0d)", tag, act, exp,
                     int'(vg), int'(vh));
        end
    endtask

    // Reference model, advanced on every rising edge.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_a = 0; e_b = 0; e_c = 0; e_cm = 0; e_done = 0; e_err = 0;
        end else begin
            bit f; int ra, rb, rc;
            e_done = start;
            e_err  = 0;
            if (start) begin
                ref_search(int'(vg), int'(vh), f, ra, rb, rc);
                if (f) begin
                    e_a = ra; e_b = rb; e_c = rc; e_cm = ra + rb + rc;
                end else e_err = 1;
            end
        end
    end

    // Compare on every falling edge once out of reset.
    always @(negedge clk) begin
        if (armed) begin
            string lt;
            lt = e_done && !e_err ? "R1 R3 R4" : (e_err ? "R7" : "R9");
            chk({lt, " sa"}, int'(sa), e_a);
            chk({lt, " sb"}, int'(sb), e_b);
            chk({lt, " sc"}, int'(sc), e_c);
            chk("R5 cm", int'(cm), e_cm);
            chk("R6 done", int'(done), int'(e_done));
            chk("R7 err", int'(err), int'(e_err));
            chk("R2 range", int'(iabs(int'(sa)) <= 2 && iabs(int'(sb)) <= 2 &&
                                 iabs(int'(sc)) <= 2), 1);
        end
    end

    task automatic req(input int g, input int h);
        vg = CW'(g); vh = CW'(h); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 sa", int'(sa), 0);
        chk("R8 sb", int'(sb), 0);
        chk("R8 sc", int'(sc), 0);
        chk("R8 cm", int'(cm), 0);
        chk("R8 done", int'(done), 0);
        chk("R8 err", int'(err), 0);
        rst_n = 1'b1;
        armed = 1;
        @(negedge clk);
        // Full sweep, including points outside the hexagon, one strobe each.
        for (int g = -6; g <= 6; g++)
            for (int h = -6; h <= 6; h++) begin
                req(g, h);
                @(negedge clk);
            end
        // Back-to-back strobes.
        for (int g = -4; g <= 4; g++) begin
            vg = CW'(g); vh = CW'(-g / 2); start = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        // Valid then invalid: state must survive the error.
        req(2, 1); req(5, 0); req(-3, -3); req(0, 0);
        // Inputs wander with no strobe (R9).
        for (int i = 0; i < 20; i++) begin
            vg = CW'(i % 9 - 4); vh = CW'(4 - i % 7);
            @(negedge clk);
        end
        // Pseudo-random mix of strobes and idle cycles.
        for (int i = 0; i < 400; i++) begin
            lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
            vg = CW'((lfsr & 15) % 13 - 6);
            vh = CW'(((lfsr >> 4) & 15) % 13 - 6);
            start = lfsr[9];
            @(negedge clk);
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        armed = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule